// File: doc/BRIEF.md
# LIN Sync Field Bit-Time Meter

This block measures the bit time of a LIN master from the sync field that follows a break. A pulse on the break-valid input arms it. The first falling edge of the bus after arming clears a 16-bit span counter and starts it. From then on the counter advances once for every pulse of a fixed 5 MHz time-base enable. That enable does not depend on the core clock or the baud rate. On the fifth falling edge the counter freezes and a done flag is raised. The sync byte (0x55, sent after a start bit) has five falling edges spread over eight bit periods, so the frozen count is eight bit times in time-base ticks.

The count is always visible at a read-only output. A second output gives the count divided by eight, which is one bit time in ticks; software loads a UART divider from it. After a result or a timeout the block disarms. Any further edges are ignored until the next valid break. If the counter reaches its ceiling before the fifth edge, a timeout flag is raised in place of done.

Top module: `lin_sync_timer`

## Requirements
- R1: After reset `span_cnt` and `bit_time` read 0, and `meas_done` and `sync_tmo` read 0.
- R2: Falling edges on `bus_rx` are ignored unless a `brk_ok` pulse has arrived since the last result or timeout. Ignored edges leave `span_cnt`, `meas_done` and `sync_tmo` unchanged.
- R3: The first falling edge after arming sets `span_cnt` to 0 in the next cycle. The counter then adds one for each cycle with `tbase_en`=1, from the cycle after the first edge up to and including the cycle of the fifth edge. Cycles with `tbase_en`=0 add nothing. A 0x55 sync field of L cycles per bit with `tbase_en` held at 1 gives 8*L.
- R4: The cycle after the fifth falling edge, `meas_done` reads 1 and `span_cnt` is frozen. The block is disarmed until the next `brk_ok`.
- R5: `bit_time` always equals `span_cnt` shifted right by 3 bits (the integer quotient by 8).
- R6: If a time-base pulse arrives while the count is 0xFFFF and before the fifth edge, `sync_tmo` reads 1 in the next cycle. `span_cnt` stays at 0xFFFF and the block disarms.
- R7: A `brk_ok` pulse clears `meas_done` and `sync_tmo` in the next cycle and restarts edge tracking from zero, even in the middle of a measurement. `span_cnt` keeps its value until the next first edge. When `brk_ok` and an edge arrive in the same cycle, `brk_ok` wins and the edge is ignored.
- R8: A falling edge is a cycle in which `bus_rx` is 0 after it was 1 in the previous cycle. The bus is taken as high (idle) out of reset, so a bus that is already low produces no edge.
- R9: `meas_done` and `sync_tmo` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rx | input | 1 | LIN receive line, already synchronized to `clk` |
| brk_ok | input | 1 | One-cycle pulse: a valid break was detected |
| tbase_en | input | 1 | One-cycle enable at the 5 MHz time-base rate |
| span_cnt | output | 16 | Span counter: live while timing, frozen after the fifth edge |
| bit_time | output | 13 | `span_cnt` divided by 8 |
| meas_done | output | 1 | Measurement complete |
| sync_tmo | output | 1 | Counter reached its ceiling before the fifth edge |

## Verification
Every result is registered once. A change caused by the inputs of cycle N shows at the outputs in cycle N+1. This covers the clearing on the first edge, each counter increment, the freeze and done flag on the fifth edge, the timeout and the flag clearing on a break. `bit_time` follows `span_cnt` in the same cycle. The bench applies stimulus on the falling clock edge and keeps a cycle-by-cycle model of the required count. It reads results only after at least one further falling edge with the bus idle, so every registered value has settled. Sweeps cover bit lengths against time-base rates, a bus that is already low at arming, a break during a measurement, and a full run of the counter up to its ceiling.

// File: rtl/lin_sync_pkg.sv
// Package: shared types of the LIN sync-field bit-time meter.
// Assumes nothing beyond IEEE 1800-2017.
package lin_sync_pkg;

    // Measurement phase of the edge sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // disarmed, edges ignored
        PH_ARMED  = 2'd1,   // break seen, waiting for first falling edge
        PH_TIMING = 2'd2    // counter running between first and last edge
    } meas_phase_t;

endpackage

// File: rtl/lin_fall_det.sv
// Module: lin_fall_det
// Flags a falling edge on an already synchronized serial line.
// Assumes the line idles high, so the history register resets to 1.
// The flag is combinational from the present input and one stored bit.
module lin_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall
);

    logic line_q;

    // Hold last cycle's line level; idle-high out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_in;
        end
    end

    // A fall is high-then-low across two consecutive cycles.
    always_comb begin
        fall = line_q & ~line_in;
    end

endmodule

// File: rtl/lin_edge_seq.sv
// Module: lin_edge_seq
// Counts falling edges of the sync field after arming and sequences
// the measurement: start pulse on the first edge, stop on the last,
// then a done or timeout flag and disarming.
// Assumes arm, fall and sat_hit are single-cycle qualified pulses.
module lin_edge_seq
    import lin_sync_pkg::*;
#(
    parameter int EDGES = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        fall,
    input  logic        sat_hit,
    output logic        start,
    output logic        run,
    output logic        idle,
    output logic        done,
    output logic        tmo
);

    localparam int EDGE_W = $clog2(EDGES + 1);
    localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

    meas_phase_t       phase;
    logic [EDGE_W-1:0] edge_cnt;
    logic              stop;

    // Decode the start and stop events; arming overrides both.
    always_comb begin
        start = (phase == PH_ARMED) && fall && !arm;
        stop  = (phase == PH_TIMING) && fall && !arm && (edge_cnt == LAST_IDX);
        run   = (phase == PH_TIMING);
        idle  = (phase == PH_IDLE);
    end

    // Phase, edge count and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            edge_cnt <= '0;
            done     <= 1'b0;
            tmo      <= 1'b0;
        end else if (arm) begin
            phase    <= PH_ARMED;
            edge_cnt <= '0;
            done     <= 1'b0;
            tmo      <= 1'b0;
        end else begin
            unique case (phase)
                PH_ARMED: begin
                    if (fall) begin
                        phase    <= PH_TIMING;
                        edge_cnt <= EDGE_W'(1);
                    end
                end
                PH_TIMING: begin
                    if (stop) begin
                        phase    <= PH_IDLE;
                        edge_cnt <= '0;
                        done     <= 1'b1;
                    end else if (fall) begin
                        edge_cnt <= edge_cnt + EDGE_W'(1);
                    end else if (sat_hit) begin
                        phase    <= PH_IDLE;
                        edge_cnt <= '0;
                        tmo      <= 1'b1;
                    end
                end
                default: begin
                    edge_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lin_span_ctr.sv
// Module: lin_span_ctr
// Saturating span counter advanced by a time-base enable while running.
// Assumes clear and run never both request an update in one cycle
// (clear takes priority if they do).
module lin_span_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             sat_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // A tick that arrives at the ceiling while running is reported.
    always_comb begin
        sat_hit = run && tick && (cnt == CNT_MAX);
    end

    // Clear on start, else count ticks up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && tick && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lin_sync_timer.sv
// Module: lin_sync_timer (top)
// Times the LIN sync field from its first to its last falling edge on
// a fixed time base, once per valid break, and presents the count and
// the count divided down to one bit time.
// Assumes bus_rx is synchronous to clk and tbase_en is a one-cycle pulse.
module lin_sync_timer #(
    parameter int CNT_W = 16,
    parameter int EDGES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rx,
    input  logic                   brk_ok,
    input  logic                   tbase_en,
    output logic [CNT_W-1:0]       span_cnt,
    output logic [CNT_W-4:0]       bit_time,
    output logic                   meas_done,
    output logic                   sync_tmo
);

    // Bit periods between first and last falling edge of 0x55 framing.
    localparam int BIT_SPAN = 2 * (EDGES - 1);
    localparam int SHIFT    = $clog2(BIT_SPAN);

    logic seq_fall;
    logic seq_start;
    logic seq_run;
    logic seq_idle;
    logic ctr_sat;

    lin_fall_det i_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (bus_rx),
        .fall    (seq_fall)
    );

    lin_edge_seq #(
        .EDGES (EDGES)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (brk_ok),
        .fall    (seq_fall),
        .sat_hit (ctr_sat),
        .start   (seq_start),
        .run     (seq_run),
        .idle    (seq_idle),
        .done    (meas_done),
        .tmo     (sync_tmo)
    );

    lin_span_ctr #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (seq_start),
        .run     (seq_run),
        .tick    (tbase_en),
        .cnt     (span_cnt),
        .sat_hit (ctr_sat)
    );

    // One bit time: the span divided by the number of bit periods.
    always_comb begin
        bit_time = (CNT_W-3)'(span_cnt >> SHIFT);
    end

endmodule

// File: rtl/lin_sync_timer_chk.sv
// Module: lin_sync_timer_chk
// Property checker for lin_sync_timer, bound to every instance.
// Assumes the default 16-bit counter for the ceiling check.
module lin_sync_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rx,
    input logic             brk_ok,
    input logic [CNT_W-1:0] span_cnt,
    input logic             meas_done,
    input logic             sync_tmo,
    input logic             seq_start,
    input logic             seq_idle
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_done && sync_tmo)); // R9

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (span_cnt == '0)); // R3

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !brk_ok) |=> ($stable(span_cnt) && $stable(meas_done) && $stable(sync_tmo))); // R2

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_done) |-> ($past(bus_rx) == 1'b0 && $past(bus_rx, 2) == 1'b1)); // R4

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !brk_ok) |=> $stable(span_cnt)); // R4

    AST_TMO_AT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_tmo) |-> (span_cnt == {CNT_W{1'b1}})); // R6

    AST_BREAK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ok |=> (!meas_done && !sync_tmo)); // R7

endmodule

bind lin_sync_timer lin_sync_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rx    (bus_rx),
    .brk_ok    (brk_ok),
    .span_cnt  (span_cnt),
    .meas_done (meas_done),
    .sync_tmo  (sync_tmo),
    .seq_start (seq_start),
    .seq_idle  (seq_idle)
);

// File: tb/test_lin_sync_timer.sv
`timescale 1ns/1ps
// Bench for lin_sync_timer: sweeps bit lengths against time-base rates
// and checks arming, restart, already-low bus and counter ceiling.
module test_lin_sync_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rx = 1'b1;
    logic        brk_ok = 1'b0;
    logic        tbase_en = 1'b0;
    logic [15:0] span_cnt;
    logic [12:0] bit_time;
    logic        meas_done;
    logic        sync_tmo;

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    int tick_per = 1;
    bit finished = 0;

    // Requirement model state.
    logic        m_prev = 1'b1;
    logic        m_armed = 1'b0;
    logic        m_meas = 1'b0;
    int          m_nf = 0;
    logic [15:0] m_cnt = '0;
    logic        m_done = 1'b0;
    logic        m_tmo = 1'b0;

    always #2.5 clk = ~clk;

    lin_sync_timer i_lin_sync_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rx    (bus_rx),
        .brk_ok    (brk_ok),
        .tbase_en  (tbase_en),
        .span_cnt  (span_cnt),
        .bit_time  (bit_time),
        .meas_done (meas_done),
        .sync_tmo  (sync_tmo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
        end
    endtask

    // One cycle of stimulus, applied on the falling edge, plus the model.
    task automatic step(input logic rxv, input logic brk);
        logic tk;
        logic fl;
        logic sat;
        tk = (tick_per != 0) && ((t % tick_per) == 0);
        @(negedge clk);
        bus_rx = rxv;
        tbase_en = tk;
        brk_ok = brk;
        fl = m_prev && !rxv;
        sat = m_meas && tk && (m_cnt == 16'hFFFF);
        if (m_meas && tk && !sat) m_cnt = m_cnt + 16'd1;
        if (brk) begin
            m_armed = 1'b1; m_meas = 1'b0; m_nf = 0; m_done = 1'b0; m_tmo = 1'b0;
        end else if (m_armed && fl) begin
            m_nf++;
            if (m_nf == 1) begin m_meas = 1'b1; m_cnt = '0; end
            if (m_nf == 5) begin m_meas = 1'b0; m_armed = 1'b0; m_done = 1'b1; end
        end else if (sat) begin
            m_meas = 1'b0; m_armed = 1'b0; m_tmo = 1'b1;
        end
        m_prev = rxv;
        t++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    // Start bit then 0x55 LSB first: levels alternate 0,1,0,1,...
    task automatic send_sync(input int len);
        for (int b = 0; b < 10; b++)
            for (int j = 0; j < len; j++) step(logic'(b % 2), 1'b0);
    endtask

    task automatic check_model(input string req);
        chk({req, " span"}, 32'(span_cnt), 32'(m_cnt));
        chk("R5 bit_time", 32'(bit_time), 32'(m_cnt >> 3));
        chk({req, " done"}, 32'(meas_done), 32'(m_done));
        chk({req, " tmo"}, 32'(sync_tmo), 32'(m_tmo));
        chk("R9 exclusive", 32'(meas_done && sync_tmo), 0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lens[6];
        lens = '{1, 2, 3, 5, 8, 13};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1: reset values.
        chk("R1 span", 32'(span_cnt), 0);
        chk("R1 bit_time", 32'(bit_time), 0);
        chk("R1 done", 32'(meas_done), 0);
        chk("R1 tmo", 32'(sync_tmo), 0);

        // R2: sync without a break is ignored.
        tick_per = 1;
        send_sync(4); idle(3);
        chk("R2 unarmed span", 32'(span_cnt), 0);
        chk("R2 unarmed done", 32'(meas_done), 0);

        // R3/R4/R5: sweep bit lengths against time-base rates.
        foreach (lens[k]) begin
            for (int p = 1; p <= 3; p++) begin
                tick_per = p;
                step(1'b1, 1'b1); idle(2);
                send_sync(lens[k]); idle(3);
                check_model("R3 R4");
                if (p == 1) chk("R3 8*L", 32'(span_cnt), 32'(8 * lens[k]));
            end
        end

        // R2/R4: after done, another sync leaves result unchanged.
        tick_per = 1;
        begin
            logic [15:0] held;
            held = span_cnt;
            send_sync(3); idle(2);
            chk("R4 frozen span", 32'(span_cnt), 32'(held));
            chk("R4 done held", 32'(meas_done), 1);
        end

        // R3/R7: first edge clears count; break cleared done.
        tick_per = 0;
        step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b0, 1'b0); idle(1);
        chk("R3 cleared", 32'(span_cnt), 0);
        chk("R7 done cleared", 32'(meas_done), 0);

        // R7: break in mid-measurement restarts tracking.
        tick_per = 1;
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b1); idle(2);
        send_sync(6); idle(2);
        chk("R7 restart span", 32'(span_cnt), 48);
        check_model("R7");

        // R7: break and edge in the same cycle, edge ignored.
        step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0);
        send_sync(2); idle(2);
        chk("R7 same-cycle span", 32'(span_cnt), 16);

        // R8: bus already low at arming yields no edge.
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        idle(4);
        send_sync(4); idle(2);
        chk("R8 span", 32'(span_cnt), 32);
        check_model("R8");

        // R6: counter ceiling before the fifth edge.
        tick_per = 1;
        step(1'b1, 1'b1); idle(1); step(1'b0, 1'b0);
        idle(65540);
        chk("R6 tmo", 32'(sync_tmo), 1);
        chk("R6 span ceiling", 32'(span_cnt), 32'hFFFF);
        chk("R6 done low", 32'(meas_done), 0);
        check_model("R6");
        send_sync(2); idle(2);
        chk("R6 disarmed span", 32'(span_cnt), 32'hFFFF);
        chk("R6 tmo held", 32'(sync_tmo), 1);
        step(1'b1, 1'b1); idle(1);
        chk("R7 tmo cleared", 32'(sync_tmo), 0);
        chk("R7 span retained", 32'(span_cnt), 32'hFFFF);
        send_sync(3); idle(2);
        chk("R4 after tmo", 32'(span_cnt), 24);
        check_model("R4");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule